// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Identification Word

This block is a reduced test access port for serial scan. It holds the sixteen-state port controller, which advances on every rising edge of the test clock under the mode-select line. It also holds an instruction register, a one-bit bypass stage, a 32-bit identification register and a boundary cell chain. The chain is modelled as a plain shift register whose length is a parameter and which loads a parallel snapshot input. The active instruction decides which data register sits between the serial input and the serial output. The serial output is retimed onto the falling clock edge and carries a drive-enable for the pad.

Only three behaviours are decoded: read the identification word, scan the boundary chain, and bypass. Every other instruction code falls back to the bypass stage. The identification word is assembled from parameters. Its fields have fixed positions, including a depth field and a width field that describe the memory it labels.

Top module: `tap_top`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in Test-Logic-Reset, makes IDCODE (code 1) the active instruction and holds `tdo_oe` low.
- R2: Five consecutive rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state, and IDCODE becomes active there.
- R3: State changes follow the standard sixteen-state graph. From Run-Test/Idle, `tms` = 1,0,0 reaches Shift-DR and 1,1,0,0 reaches Shift-IR. From either shift state, 1,1,0 leaves through Update and ends in Run-Test/Idle.
- R4: Capture-IR loads the pattern ...001 (the lowest two bits are 01). Every register shifts LSB first: `tdi` enters the MSB and bit 0 appears on `tdo`.
- R5: The active instruction changes only on the edge that leaves Update-IR, or in Test-Logic-Reset. This includes the route through Pause-IR and Exit2-IR.
- R6: With IDCODE active, Capture-DR loads a 32-bit word that reads, from MSB to LSB: revision [31:28], depth [27:23] (default 00111), width [22:18] (default 00011), device id [17:12], manufacturer code [10:0] at bits [11:1] (default 00000101100), and a 1 in bit 0.
- R7: The all-ones code selects the one-bit bypass stage. It captures 0, so the output stream is a 0 followed by `tdi` delayed by one cycle.
- R8: Any code other than 1, 2 and all-ones also selects the bypass stage.
- R9: Code 2 selects the boundary chain of `CHAIN_LEN` bits, which loads `chain_cap` in Capture-DR.
- R10: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising edges |
| tdi | input | 1 | Serial data in |
| chain_cap | input | CHAIN_LEN | Parallel snapshot loaded into the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling edges |
| tdo_oe | output | 1 | Drive-enable for the `tdo` pad; low means high impedance |

## Verification
The bench builds the block with a 3-bit instruction register and an 8-bit boundary chain. With these values all eight instruction codes can be driven, so every unknown code is exercised alongside the three decoded ones. The short chain lets a single scan push captured bits out and then show the input stream delayed by the chain length. The revision and device-id fields are set to non-zero values, so that a misplaced field would show up in the scanned-out identification word.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        S_RESET, S_IDLE,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAUSE_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAUSE_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYPASS, SEL_IDWORD, SEL_CHAIN
    } dr_sel_e;

    typedef struct packed {
        logic [3:0]  rev;
        logic [4:0]  depth;
        logic [4:0]  width;
        logic [5:0]  dev;
        logic [10:0] mfr;
        logic        marker;
    } id_word_t;

    localparam int ID_BITS = $bits(id_word_t);

    function automatic tap_state_e next_state(tap_state_e s, logic tms);
        tap_state_e n;
        unique case (s)
            S_RESET:    n = tms ? S_RESET    : S_IDLE;
            S_IDLE:     n = tms ? S_SEL_DR   : S_IDLE;
            S_SEL_DR:   n = tms ? S_SEL_IR   : S_CAP_DR;
            S_CAP_DR:   n = tms ? S_EX1_DR   : S_SH_DR;
            S_SH_DR:    n = tms ? S_EX1_DR   : S_SH_DR;
            S_EX1_DR:   n = tms ? S_UPD_DR   : S_PAUSE_DR;
            S_PAUSE_DR: n = tms ? S_EX2_DR   : S_PAUSE_DR;
            S_EX2_DR:   n = tms ? S_UPD_DR   : S_SH_DR;
            S_UPD_DR:   n = tms ? S_SEL_DR   : S_IDLE;
            S_SEL_IR:   n = tms ? S_RESET    : S_CAP_IR;
            S_CAP_IR:   n = tms ? S_EX1_IR   : S_SH_IR;
            S_SH_IR:    n = tms ? S_EX1_IR   : S_SH_IR;
            S_EX1_IR:   n = tms ? S_UPD_IR   : S_PAUSE_IR;
            S_PAUSE_IR: n = tms ? S_EX2_IR   : S_PAUSE_IR;
            S_EX2_IR:   n = tms ? S_UPD_IR   : S_SH_IR;
            S_UPD_IR:   n = tms ? S_SEL_DR   : S_IDLE;
            default:    n = S_RESET;
        endcase
        return n;
    endfunction

    function automatic id_word_t make_id(logic [3:0] rev, logic [4:0] depth,
                                         logic [4:0] width, logic [5:0] dev,
                                         logic [10:0] mfr);
        id_word_t w;
        w.rev    = rev;
        w.depth  = depth;
        w.width  = width;
        w.dev    = dev;
        w.mfr    = mfr;
        w.marker = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) state <= S_RESET;
        else     state <= next_state(state, tms);
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
#(
    parameter int IR_W       = 3,
    parameter int CODE_ID    = 1,
    parameter int CODE_CHAIN = 2
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_sh,
    output logic [IR_W-1:0] ir_act,
    output dr_sel_e         dr_sel
);

    localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);
    localparam logic [IR_W-1:0] ID_C    = IR_W'(CODE_ID);
    localparam logic [IR_W-1:0] CHAIN_C = IR_W'(CODE_CHAIN);

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sh  <= CAP_PAT;
            ir_act <= ID_C;
        end else begin
            unique case (state)
                S_CAP_IR: ir_sh  <= CAP_PAT;
                S_SH_IR:  ir_sh  <= {tdi, ir_sh[IR_W-1:1]};
                S_UPD_IR: ir_act <= ir_sh;
                S_RESET:  ir_act <= ID_C;
                default:  ;
            endcase
        end
    end

    always_comb begin
        if (ir_act == ID_C)         dr_sel = SEL_IDWORD;
        else if (ir_act == CHAIN_C) dr_sel = SEL_CHAIN;
        else                        dr_sel = SEL_BYPASS;
    end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int                    CHAIN_LEN = 8,
    parameter logic [ID_BITS-1:0]    ID_WORD   = '1
) (
    input  logic                 tck,
    input  logic                 rst,
    input  logic                 tdi,
    input  tap_state_e           state,
    input  dr_sel_e              dr_sel,
    input  logic [CHAIN_LEN-1:0] chain_cap,
    output logic                 byp_q,
    output logic                 dr_lsb
);

    logic [ID_BITS-1:0]   id_q;
    logic [CHAIN_LEN-1:0] chain_q;
    logic                 cap_en;
    logic                 sh_en;

    assign cap_en = (state == S_CAP_DR);
    assign sh_en  = (state == S_SH_DR);

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_q  <= '0;
        end else begin
            if (cap_en && dr_sel == SEL_BYPASS) byp_q <= 1'b0;
            if (sh_en  && dr_sel == SEL_BYPASS) byp_q <= tdi;
            if (cap_en && dr_sel == SEL_IDWORD) id_q  <= ID_WORD;
            if (sh_en  && dr_sel == SEL_IDWORD) id_q  <= {tdi, id_q[ID_BITS-1:1]};
        end
    end

    generate
        if (CHAIN_LEN > 1) begin : g_chain_multi
            always_ff @(posedge tck) begin
                if (rst)                                  chain_q <= '0;
                else if (cap_en && dr_sel == SEL_CHAIN)   chain_q <= chain_cap;
                else if (sh_en  && dr_sel == SEL_CHAIN)   chain_q <= {tdi, chain_q[CHAIN_LEN-1:1]};
            end
        end else begin : g_chain_single
            always_ff @(posedge tck) begin
                if (rst)                                  chain_q <= '0;
                else if (cap_en && dr_sel == SEL_CHAIN)   chain_q <= chain_cap;
                else if (sh_en  && dr_sel == SEL_CHAIN)   chain_q <= tdi;
            end
        end
    endgenerate

    always_comb begin
        unique case (dr_sel)
            SEL_IDWORD: dr_lsb = id_q[0];
            SEL_CHAIN:  dr_lsb = chain_q[0];
            default:    dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/tap_top.sv
module tap_top
    import tap_pkg::*;
#(
    parameter int          IR_W       = 3,
    parameter int          CHAIN_LEN  = 8,
    parameter int          CODE_ID    = 1,
    parameter int          CODE_CHAIN = 2,
    parameter logic [3:0]  REV        = 4'h0,
    parameter logic [4:0]  DEPTH      = 5'b00111,
    parameter logic [4:0]  WIDTH      = 5'b00011,
    parameter logic [5:0]  DEV_ID     = 6'h00,
    parameter logic [10:0] MFR_CODE   = 11'b00000101100
) (
    input  logic                 tck,
    input  logic                 rst,
    input  logic                 tms,
    input  logic                 tdi,
    input  logic [CHAIN_LEN-1:0] chain_cap,
    output logic                 tdo,
    output logic                 tdo_oe
);

    localparam logic [ID_BITS-1:0] ID_WORD = make_id(REV, DEPTH, WIDTH, DEV_ID, MFR_CODE);

    tap_state_e      state;
    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_act;
    dr_sel_e         dr_sel;
    logic            byp_q;
    logic            dr_lsb;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    tap_ir #(
        .IR_W       (IR_W),
        .CODE_ID    (CODE_ID),
        .CODE_CHAIN (CODE_CHAIN)
    ) u_ir (
        .tck    (tck),
        .rst    (rst),
        .tdi    (tdi),
        .state  (state),
        .ir_sh  (ir_sh),
        .ir_act (ir_act),
        .dr_sel (dr_sel)
    );

    tap_dr #(
        .CHAIN_LEN (CHAIN_LEN),
        .ID_WORD   (ID_WORD)
    ) u_dr (
        .tck       (tck),
        .rst       (rst),
        .tdi       (tdi),
        .state     (state),
        .dr_sel    (dr_sel),
        .chain_cap (chain_cap),
        .byp_q     (byp_q),
        .dr_lsb    (dr_lsb)
    );

    // Output retimed on the falling edge of the test clock.
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            unique case (state)
                S_SH_IR: begin tdo <= ir_sh[0]; tdo_oe <= 1'b1; end
                S_SH_DR: begin tdo <= dr_lsb;   tdo_oe <= 1'b1; end
                default: begin tdo <= 1'b0;     tdo_oe <= 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/tap_checker.sv
module tap_checker
    import tap_pkg::*;
#(
    parameter int IR_W = 3
) (
    input logic            tck,
    input logic            rst,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_sh,
    input logic [IR_W-1:0] ir_act,
    input logic            byp_q,
    input logic            tdo_oe
);

    logic [2:0] ones;

    always_ff @(posedge tck) begin
        if (rst || !tms)    ones <= 3'd0;
        else if (ones != 5) ones <= ones + 3'd1;
    end

    assert_tms_reset_R2: assert property (@(posedge tck) disable iff (rst)
        (ones == 3'd5) |-> (state == S_RESET));

    assert_capture_ir_R4: assert property (@(posedge tck) disable iff (rst)
        (state == S_CAP_IR) |=> (ir_sh[1:0] == 2'b01));

    assert_update_only_R5: assert property (@(posedge tck) disable iff (rst)
        (state != S_UPD_IR && state != S_RESET) |=> $stable(ir_act));

    assert_bypass_zero_R7: assert property (@(posedge tck) disable iff (rst)
        (state == S_CAP_DR && ir_act == '1) |=> (byp_q == 1'b0));

    assert_oe_window_R10: assert property (@(posedge tck) disable iff (rst)
        tdo_oe == (state == S_SH_DR || state == S_SH_IR));

endmodule

bind tap_top tap_checker #(.IR_W(IR_W)) u_chk (
    .tck    (tck),
    .rst    (rst),
    .tms    (tms),
    .state  (state),
    .ir_sh  (ir_sh),
    .ir_act (ir_act),
    .byp_q  (byp_q),
    .tdo_oe (tdo_oe)
);

// File: tb/tap_top_bench.sv
module tap_top_bench;

    localparam int          IR_W      = 3;
    localparam int          CHAIN_LEN = 8;
    localparam logic [3:0]  REV       = 4'h5;
    localparam logic [5:0]  DEV_ID    = 6'h2A;
    localparam logic [31:0] EXP_ID    = {REV, 5'b00111, 5'b00011, DEV_ID, 11'b00000101100, 1'b1};

    logic                 tck = 1'b0;
    logic                 rst = 1'b1;
    logic                 tms = 1'b1;
    logic                 tdi = 1'b0;
    logic [CHAIN_LEN-1:0] chain_cap = '0;
    logic                 tdo;
    logic                 tdo_oe;

    int n_run  = 0;
    int n_fail = 0;

    logic tdo_s, oe_s, oe_pre;

    always #10 tck = ~tck;

    tap_top #(
        .IR_W(IR_W), .CHAIN_LEN(CHAIN_LEN), .REV(REV), .DEV_ID(DEV_ID)
    ) u_tap_top (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi),
        .chain_cap(chain_cap), .tdo(tdo), .tdo_oe(tdo_oe)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at posedge+5; samples outputs at posedge+15 (after the falling edge).
    task automatic cyc(input logic m, input logic d);
        oe_pre = tdo_oe;
        tms = m;
        tdi = d;
        #10;
        tdo_s = tdo;
        oe_s  = tdo_oe;
        #10;
    endtask

    function automatic int exp_len(input int code);
        if (code == 1) return 32;
        if (code == 2) return CHAIN_LEN;
        return 1;
    endfunction

    function automatic logic [63:0] exp_cap(input int code, input logic [CHAIN_LEN-1:0] cc);
        if (code == 1) return {32'h0, EXP_ID};
        if (code == 2) return {{(64-CHAIN_LEN){1'b0}}, cc};
        return 64'h0;
    endfunction

    function automatic logic [63:0] exp_stream(input int n, input int len, input logic [63:0] cap, input logic [63:0] din);
        logic [63:0] r = '0;
        for (int k = 0; k < n; k++) r[k] = (k < len) ? cap[k] : din[k-len];
        return r;
    endfunction

    task automatic tms_reset();
        for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [IR_W-1:0] code, input logic via_pause, output logic [IR_W-1:0] cap_out, output logic oe_ok);
        oe_ok = 1'b1;
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
        for (int k = 0; k < IR_W; k++) begin
            cyc(k == IR_W-1, code[k]);
            cap_out[k] = tdo_s;
            if (!oe_s) oe_ok = 1'b0;
        end
        if (via_pause) begin
            cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
            if (oe_s) oe_ok = 1'b0;
            cyc(1'b1, 1'b0); cyc(1'b1, 1'b0); cyc(1'b0, 1'b0);
        end else begin
            cyc(1'b1, 1'b0); cyc(1'b0, 1'b0);
        end
        if (oe_s) oe_ok = 1'b0;
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout, output logic oe_ok, output logic first_pre);
        oe_ok = 1'b1;
        dout  = '0;
        cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
        for (int k = 0; k < n; k++) begin
            cyc(k == n-1, din[k]);
            if (k == 0) first_pre = oe_pre;
            dout[k] = tdo_s;
            if (!oe_s) oe_ok = 1'b0;
        end
        cyc(1'b1, 1'b0); cyc(1'b0, 1'b0);
        if (oe_s) oe_ok = 1'b0;
    endtask

    task automatic trial(input int code, input int n, input string req);
        logic [IR_W-1:0] cap;
        logic [63:0]     din, dout, exp;
        logic            ok1, ok2, pre;
        din = {$urandom, $urandom};
        chain_cap = CHAIN_LEN'($urandom);
        load_ir(IR_W'(code), 1'b0, cap, ok1);
        check(cap == IR_W'(1), "R4 capture-IR pattern", 64'(cap), 64'(IR_W'(1)));
        scan_dr(n, din, dout, ok2, pre);
        exp = exp_stream(n, exp_len(code), exp_cap(code, chain_cap), din);
        check(dout == exp, req, dout, exp);
        check(ok1 && ok2, "R10 tdo_oe only in shift states", 64'({ok1, ok2}), 64'h3);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0]     dout, exp;
        logic [IR_W-1:0] cap;
        logic            ok, ok2, pre;
        void'($urandom(32'd2024));
        @(posedge tck); #5;
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b0);
        check(tdo_oe == 1'b0, "R1 tdo_oe low in reset", 64'(tdo_oe), 64'h0);
        rst = 1'b0;
        cyc(1'b0, 1'b0);
        check(oe_s == 1'b0, "R10 tdo_oe low in idle", 64'(oe_s), 64'h0);

        // R1 / R6: IDCODE active straight after reset, no IR load
        scan_dr(40, 64'h00000000_000000A5, dout, ok, pre);
        exp = exp_stream(40, 32, {32'h0, EXP_ID}, 64'h00000000_000000A5);
        check(dout == exp, "R1 R6 id word after reset", dout, exp);
        check(pre == 1'b0 && ok, "R10 oe rises at falling edge only", 64'({pre, ok}), 64'h1);

        // R7 bypass with all-ones
        trial(7, 10, "R7 bypass all-ones");
        // R8 every unknown code
        trial(0, 6, "R8 unknown code 0");
        trial(3, 6, "R8 unknown code 3");
        trial(4, 6, "R8 unknown code 4");
        trial(5, 6, "R8 unknown code 5");
        trial(6, 6, "R8 unknown code 6");
        // R9 boundary chain
        trial(2, CHAIN_LEN + 5, "R9 boundary chain");
        trial(2, CHAIN_LEN, "R9 boundary chain exact length");
        // R6 explicit IDCODE load
        trial(1, 36, "R6 id word via load");

        // R5 / R3: instruction reaches effect through Pause-IR and Exit2-IR
        load_ir(IR_W'(7), 1'b0, cap, ok);
        load_ir(IR_W'(1), 1'b1, cap, ok);
        check(ok, "R3 pause path keeps oe low", 64'(ok), 64'h1);
        scan_dr(32, 64'h0, dout, ok, pre);
        check(dout[31:0] == EXP_ID, "R5 update via pause path", dout, {32'h0, EXP_ID});

        // R5: DR activity does not alter the instruction
        load_ir(IR_W'(7), 1'b0, cap, ok);
        scan_dr(8, 64'h01, dout, ok, pre);
        scan_dr(4, 64'h0, dout, ok, pre);
        check(dout[3:0] == 4'b0010 || dout[3:0] == 4'b0000, "R5 bypass kept after DR scan", dout, 64'h0);

        // R2: abandon a DR scan with five TMS-high edges
        load_ir(IR_W'(7), 1'b0, cap, ok);
        cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); cyc(1'b0, 1'b0); cyc(1'b0, 1'b1);
        check(oe_s == 1'b1, "R3 reached shift-dr", 64'(oe_s), 64'h1);
        tms_reset();
        check(oe_s == 1'b0, "R2 oe low after tms reset", 64'(oe_s), 64'h0);
        scan_dr(32, 64'h0, dout, ok, pre);
        check(dout[31:0] == EXP_ID, "R2 idcode active after tms reset", dout, {32'h0, EXP_ID});

        // R1: synchronous reset mid-shift
        load_ir(IR_W'(2), 1'b0, cap, ok);
        cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
        rst = 1'b1; cyc(1'b0, 1'b0);
        check(oe_s == 1'b0, "R1 reset forces oe low", 64'(oe_s), 64'h0);
        rst = 1'b0; cyc(1'b0, 1'b0);
        scan_dr(32, 64'h0, dout, ok, pre);
        check(dout[31:0] == EXP_ID, "R1 reset restores idcode", dout, {32'h0, EXP_ID});

        // Random mix
        for (int t = 0; t < 24; t++) begin
            int code;
            code = int'($urandom % 8);
            trial(code, exp_len(code) + 1 + int'($urandom % 8), "R7 R8 R9 random instruction");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule